// File: doc/BRIEF.md
# Packet Page Allocator

This block keeps track of a small pool of fixed-size packet pages. It holds one bit per page to show which pages are in use. It also holds three queues of page numbers: received pages waiting for the host, pages waiting to be sent, and sent pages whose completion the host has not yet acknowledged. The block does not store packet data. It hands out page numbers, queues them and takes them back.

The host works the block through a command strobe with a three-bit opcode and a packet-number register that it loads separately. The receive side of the MAC asks for a page with `rx_req` and gets a same-cycle grant or refusal. A `tx_start` strobe sends the page at the head of the transmit queue. `done_pop` acknowledges the oldest completion entry.

A transmit allocation that cannot be served is not lost. The result register holds the fail code 0x80, and the next page release fills the request at once.

Top module: `page_alloc_ctl`

## Requirements
- R1: After reset, `alloc_result` is 0, `pages_used` is 0, `alloc_done` and `rx_pending` are 0, and both `rx_head` and `done_head` read 0x80.
- R2: Opcode 1 (allocate for transmit) takes the lowest-numbered free page and marks it used. `alloc_result` then shows that page number and `alloc_done` is set.
- R3: When every page is in use, opcode 1 leaves `alloc_result` at the fail code 0x80 and `alloc_done` at 0.
- R4: A page release that happens while `alloc_result` is 0x80 retries the allocation in the same cycle. The retry uses the lowest free page, and on success it updates `alloc_result` and sets `alloc_done`.
- R5: Opcode 2 empties the page map and all three queues, and sets `alloc_result` to 0.
- R6: A receive request is granted with the lowest free page, and that page goes to the tail of the receive queue with `rx_pending` set. The request is refused (`rx_fail`) when `rx_enable` is 0, when `soft_reset` is 1, when all pages are used, or when the receive queue is full.
- R7: Opcode 3 removes the receive-queue head and moves the other entries forward. `rx_pending` stays set while entries remain and clears when the queue empties. Opcode 4 does the same and also frees the removed page.
- R8: Opcode 5 frees the page in the packet-number register. Opcode 6 appends that register to the transmit queue; on a full queue it has no effect. Opcode 7 empties the transmit and completion queues.
- R9: `tx_start` removes the transmit-queue head. With `auto_release` set, the page is freed. Otherwise the page is appended to the completion queue, unless that queue already holds four entries. `done_pop` removes the completion-queue head.
- R10: When a host command and a receive request arrive in the same cycle, the command is applied first, and the receive request sees the state the command leaves.
- R11: `rx_head` and `done_head` read 0x80 when their queue is empty. Otherwise they show the head page number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 3 | Command opcode (top three bits of the command byte) |
| pnum_wr | input | 1 | Load the packet-number register |
| pnum_in | input | 8 | Packet-number value to load |
| tx_start | input | 1 | Send the transmit-queue head |
| auto_release | input | 1 | Free sent pages instead of reporting them |
| done_pop | input | 1 | Acknowledge the completion-queue head |
| rx_enable | input | 1 | Receive enabled |
| soft_reset | input | 1 | Soft reset active; refuses receive |
| rx_req | input | 1 | MAC asks for a receive page |
| rx_grant | output | 1 | Receive request granted this cycle |
| rx_fail | output | 1 | Receive request refused this cycle |
| rx_page | output | PW | Page granted to the receive side |
| alloc_result | output | 8 | Transmit allocation result, 0x80 while pending or failed |
| alloc_done | output | 1 | Transmit allocation completed |
| rx_pending | output | 1 | Received pages are waiting |
| rx_head | output | 8 | Receive-queue head or 0x80 |
| done_head | output | 8 | Completion-queue head or 0x80 |
| pages_used | output | CW | Number of pages in use |
| tx_level | output | CW | Transmit-queue occupancy |

## Verification
Transmit allocation is swept from an empty map to a full map, which shows whether the lowest-index search is correct at every fill level. Each single-page release is then swept from a full map with a pending request. This shows whether the retry picks exactly the page that was freed. Receive allocation is tried with each of its refusal causes on its own, and queue removal is tried with and without release. Reading back which page comes free separates the two removal opcodes. Both transmit-completion policies are checked, along with a completion queue pushed past its capacity, and a same-cycle collision between a command and a receive request.

// File: rtl/page_alloc_ctl.sv
module page_alloc_ctl #(
  parameter int PAGES = 4,
  parameter logic [7:0] FAIL_CODE = 8'h80,
  localparam int PW = $clog2(PAGES),
  localparam int CW = $clog2(PAGES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic          pnum_wr,
  input  logic [7:0]    pnum_in,
  input  logic          tx_start,
  input  logic          auto_release,
  input  logic          done_pop,
  input  logic          rx_enable,
  input  logic          soft_reset,
  input  logic          rx_req,
  output logic          rx_grant,
  output logic          rx_fail,
  output logic [PW-1:0] rx_page,
  output logic [7:0]    alloc_result,
  output logic          alloc_done,
  output logic          rx_pending,
  output logic [7:0]    rx_head,
  output logic [7:0]    done_head,
  output logic [CW-1:0] pages_used,
  output logic [CW-1:0] tx_level
);
  localparam logic [PAGES-1:0] FULL = '1;
  localparam logic [CW-1:0] QMAX = CW'(PAGES);

  logic [PAGES-1:0] map, m_n;
  logic [PW-1:0] rq [PAGES], rq_n [PAGES];
  logic [PW-1:0] tq [PAGES], tq_n [PAGES];
  logic [PW-1:0] cq [PAGES], cq_n [PAGES];
  logic [CW-1:0] rn, rn_n, tn, tn_n, cn, cn_n;
  logic [7:0] res, res_n, pnum;
  logic ad_n, rs_n, rel, gr;
  logic [PW-1:0] rel_p, sent, fp;

  function automatic logic [PW-1:0] low_free(input logic [PAGES-1:0] m);
    low_free = '0;
    for (int i = PAGES - 1; i >= 0; i--)
      if (!m[i]) low_free = PW'(i);
  endfunction

  always_comb begin
    m_n = map; rq_n = rq; tq_n = tq; cq_n = cq;
    rn_n = rn; tn_n = tn; cn_n = cn;
    res_n = res; ad_n = alloc_done; rs_n = rx_pending;
    rel = 1'b0; rel_p = '0; sent = '0; fp = '0; gr = 1'b0;

    if (cmd_valid) begin
      case (cmd_op)
        3'd1: begin
          res_n = FAIL_CODE;
          ad_n = 1'b0;
          if (m_n != FULL) begin
            fp = low_free(m_n);
            m_n[fp] = 1'b1;
            res_n = 8'(fp);
            ad_n = 1'b1;
          end
        end
        3'd2: begin
          m_n = '0; rn_n = '0; tn_n = '0; cn_n = '0;
          res_n = '0; rs_n = 1'b0;
        end
        3'd3, 3'd4: begin
          if (rn_n != '0) begin
            if (cmd_op == 3'd4) begin
              rel = 1'b1;
              rel_p = rq_n[0];
            end
            for (int i = 0; i < PAGES - 1; i++) rq_n[i] = rq_n[i+1];
            rn_n = rn_n - 1'b1;
          end
          rs_n = (rn_n != '0);
        end
        3'd5: begin
          rel = 1'b1;
          rel_p = pnum[PW-1:0];
        end
        3'd6: begin
          if (tn_n < QMAX) begin
            tq_n[tn_n[PW-1:0]] = pnum[PW-1:0];
            tn_n = tn_n + 1'b1;
          end
        end
        3'd7: begin
          tn_n = '0;
          cn_n = '0;
        end
        default: ;
      endcase
    end

    if (rel) begin
      m_n[rel_p] = 1'b0;
      if (res_n == FAIL_CODE && m_n != FULL) begin
        fp = low_free(m_n);
        m_n[fp] = 1'b1;
        res_n = 8'(fp);
        ad_n = 1'b1;
      end
    end

    if (tx_start && tn_n != '0) begin
      sent = tq_n[0];
      for (int i = 0; i < PAGES - 1; i++) tq_n[i] = tq_n[i+1];
      tn_n = tn_n - 1'b1;
      if (auto_release) begin
        m_n[sent] = 1'b0;
        if (res_n == FAIL_CODE && m_n != FULL) begin
          fp = low_free(m_n);
          m_n[fp] = 1'b1;
          res_n = 8'(fp);
          ad_n = 1'b1;
        end
      end else if (cn_n < QMAX) begin
        cq_n[cn_n[PW-1:0]] = sent;
        cn_n = cn_n + 1'b1;
      end
    end

    if (done_pop && cn_n != '0) begin
      for (int i = 0; i < PAGES - 1; i++) cq_n[i] = cq_n[i+1];
      cn_n = cn_n - 1'b1;
    end

    if (rx_req && rx_enable && !soft_reset && m_n != FULL && rn_n < QMAX) begin
      gr = 1'b1;
      fp = low_free(m_n);
      m_n[fp] = 1'b1;
      rq_n[rn_n[PW-1:0]] = fp;
      rn_n = rn_n + 1'b1;
      rs_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map <= '0; rn <= '0; tn <= '0; cn <= '0;
      res <= '0; alloc_done <= 1'b0; rx_pending <= 1'b0; pnum <= '0;
      for (int i = 0; i < PAGES; i++) begin
        rq[i] <= '0; tq[i] <= '0; cq[i] <= '0;
      end
    end else begin
      map <= m_n; rq <= rq_n; tq <= tq_n; cq <= cq_n;
      rn <= rn_n; tn <= tn_n; cn <= cn_n;
      res <= res_n; alloc_done <= ad_n; rx_pending <= rs_n;
      if (pnum_wr) pnum <= pnum_in;
    end
  end

  assign rx_grant     = gr;
  assign rx_fail      = rx_req && !gr;
  assign rx_page      = rq_n[rn_n[PW-1:0] - 1'b1];
  assign alloc_result = res;
  assign rx_head      = (rn == '0) ? FAIL_CODE : 8'(rq[0]);
  assign done_head    = (cn == '0) ? FAIL_CODE : 8'(cq[0]);
  assign pages_used   = CW'($countones(map));
  assign tx_level     = tn;

  assert_one_response_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_grant && rx_fail));
  assert_grant_sets_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_grant |=> rx_pending);
  assert_full_alloc_fails_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd1 && pages_used == QMAX && !tx_start)
      |=> (alloc_result == FAIL_CODE && !alloc_done));
  assert_reset_cmd_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd2 && !rx_req)
      |=> (pages_used == '0 && tx_level == '0 && rx_head == FAIL_CODE && done_head == FAIL_CODE));
  assert_host_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd1 && pages_used == QMAX - 1'b1 && !tx_start) |-> !rx_grant);
  assert_txq_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= QMAX);
endmodule

// File: tb/sim_page_alloc_ctl.sv
module sim_page_alloc_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 0, pnum_wr = 0, tx_start = 0, auto_release = 0, done_pop = 0;
  logic rx_enable = 0, soft_reset = 0, rx_req = 0;
  logic [2:0] cmd_op = '0;
  logic [7:0] pnum_in = '0;
  logic rx_grant, rx_fail, alloc_done, rx_pending;
  logic [1:0] rx_page;
  logic [7:0] alloc_result, rx_head, done_head;
  logic [2:0] pages_used, tx_level;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  page_alloc_ctl u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .pnum_wr(pnum_wr), .pnum_in(pnum_in), .tx_start(tx_start),
    .auto_release(auto_release), .done_pop(done_pop), .rx_enable(rx_enable),
    .soft_reset(soft_reset), .rx_req(rx_req), .rx_grant(rx_grant), .rx_fail(rx_fail),
    .rx_page(rx_page), .alloc_result(alloc_result), .alloc_done(alloc_done),
    .rx_pending(rx_pending), .rx_head(rx_head), .done_head(done_head),
    .pages_used(pages_used), .tx_level(tx_level));

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic op(input logic [2:0] o);
    @(negedge clk); cmd_valid = 1; cmd_op = o;
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic setp(input int n);
    @(negedge clk); pnum_wr = 1; pnum_in = 8'(n);
    @(negedge clk); pnum_wr = 0;
  endtask

  task automatic send();
    @(negedge clk); tx_start = 1;
    @(negedge clk); tx_start = 0;
  endtask

  task automatic ack();
    @(negedge clk); done_pop = 1;
    @(negedge clk); done_pop = 0;
  endtask

  task automatic rx(output logic g, output logic f, output int pg);
    @(negedge clk); rx_req = 1;
    #1 g = rx_grant; f = rx_fail; pg = int'(rx_page);
    @(negedge clk); rx_req = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic g, f;
    int pg;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 result", alloc_result, 0);
    chk("R1 used", pages_used, 0);
    chk("R1 done", alloc_done, 0);
    chk("R1 pending", rx_pending, 0);
    chk("R1 R11 rx_head", rx_head, 128);
    chk("R1 R11 done_head", done_head, 128);

    for (int k = 0; k < 4; k++) begin
      op(3'd1);
      chk("R2 page", alloc_result, k);
      chk("R2 done", alloc_done, 1);
      chk("R2 used", pages_used, k + 1);
    end
    op(3'd1);
    chk("R3 result", alloc_result, 128);
    chk("R3 done", alloc_done, 0);

    for (int r = 0; r < 4; r++) begin
      setp(r);
      op(3'd5);
      chk("R4 retry page", alloc_result, r);
      chk("R4 retry done", alloc_done, 1);
      chk("R4 used", pages_used, 4);
      op(3'd1);
      chk("R4 pending again", alloc_result, 128);
    end

    setp(1); op(3'd6);
    op(3'd2);
    chk("R5 used", pages_used, 0);
    chk("R5 result", alloc_result, 0);
    chk("R5 txq", tx_level, 0);

    rx_enable = 0;
    rx(g, f, pg);
    chk("R6 disabled refused", f, 1);
    chk("R6 disabled no grant", g, 0);
    rx_enable = 1; soft_reset = 1;
    rx(g, f, pg);
    chk("R6 soft reset refused", f, 1);
    soft_reset = 0;
    chk("R6 nothing taken", pages_used, 0);
    for (int k = 0; k < 4; k++) begin
      rx(g, f, pg);
      chk("R6 grant", g, 1);
      chk("R6 page", pg, k);
    end
    chk("R6 pending", rx_pending, 1);
    rx(g, f, pg);
    chk("R6 full refused", f, 1);

    op(3'd2);
    op(3'd1); op(3'd1); op(3'd1); op(3'd1);
    rx(g, f, pg);
    chk("R6 map full refused", f, 1);
    chk("R6 rx queue empty", rx_head, 128);

    op(3'd2);
    for (int k = 0; k < 3; k++) rx(g, f, pg);
    chk("R7 head", rx_head, 0);
    op(3'd3);
    chk("R7 shifted head", rx_head, 1);
    chk("R7 still pending", rx_pending, 1);
    chk("R7 no release", pages_used, 3);
    op(3'd4);
    chk("R7 head after op4", rx_head, 2);
    chk("R7 released", pages_used, 2);
    op(3'd4);
    chk("R7 R11 empty head", rx_head, 128);
    chk("R7 pending cleared", rx_pending, 0);
    op(3'd1);
    chk("R7 freed page reused", alloc_result, 1);

    op(3'd2);
    for (int k = 0; k < 4; k++) op(3'd1);
    for (int k = 0; k < 4; k++) begin setp(k); op(3'd6); end
    chk("R8 txq full", tx_level, 4);
    op(3'd6);
    chk("R8 full enqueue ignored", tx_level, 4);
    op(3'd7);
    chk("R8 txq cleared", tx_level, 0);

    auto_release = 0;
    setp(2); op(3'd6); setp(0); op(3'd6);
    send(); send();
    chk("R9 completion head", done_head, 2);
    chk("R9 kept pages", pages_used, 4);
    ack();
    chk("R9 after ack", done_head, 0);
    auto_release = 1;
    setp(3); op(3'd6); send();
    chk("R9 auto release", pages_used, 3);
    chk("R9 no completion", done_head, 0);
    auto_release = 0;

    op(3'd2);
    for (int k = 0; k < 4; k++) op(3'd1);
    for (int k = 0; k < 4; k++) begin setp(k); op(3'd6); send(); end
    setp(0); op(3'd6); send();
    for (int k = 0; k < 4; k++) begin
      chk("R9 capped queue", done_head, k);
      ack();
    end
    chk("R9 R11 completion empty", done_head, 128);

    op(3'd2);
    op(3'd1); op(3'd1); op(3'd1);
    @(negedge clk); cmd_valid = 1; cmd_op = 3'd1; rx_req = 1;
    #1 f = rx_fail;
    @(negedge clk); cmd_valid = 0; rx_req = 0;
    chk("R10 host gets last page", alloc_result, 3);
    chk("R10 rx refused", f, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule